// File: doc/BRIEF.md
# Acquisition and DMA Control/Status Register Bank

This block is the processor-facing register file of a data-acquisition and DMA subsystem. A processor issues 32-bit word reads and writes on a simple valid/ready bus. The bank stores the settings that drive the surrounding logic. It also returns live status flags sampled from that logic, and it turns writes to certain offsets into single-clock command strobes. A fixed identification word lets software detect the firmware revision.

Before decode the address is filtered through a sparse mask, so many bus addresses alias onto each register. Address-valued settings keep only their upper bits. Acquisition addresses have 128-byte granularity and buffer settings have 4 KiB granularity. A level interrupt output combines a software enable with a pending flag from the acquisition side.

Top module: `acq_regbank`

## Requirements
- R1: After synchronous reset, bus_ready, every control output, every strobe output and irq are 0, and reading any read/write register returns 0.
- R2: An access is taken in a cycle where bus_valid is 1 and bus_ready is 0. bus_ready is 1 for exactly the following cycle, and for a read bus_rdata holds the result in that cycle.
- R3: Before decode the address is ANDed with 0x0010FFFC. Bits 1:0, bits 19:16 and bits 31:21 have no effect, so, for example, 0xFFEF0407 reaches offset 0x404.
- R4: Offset 0x000 reads 0x4A010003 (tag 0x4A, API version 1, major 0, minor 3). Writes to it change nothing.
- R5: Offset 0x010 bit 0 is the interrupt enable and offset 0x100 bit 0 is the DMA enable. Offset 0x404 bits 7:0 is the LED test value, which drives led_out. All three read back what was written, and the other bits read 0.
- R6: Offsets 0x200, 0x204, 0x208 and 0x20C hold the acquisition start, end, limit and interrupt addresses. Only bits 31:7 are kept. Bits 6:0 read as 0 and are 0 on the outputs.
- R7: Offset 0x100000 holds the buffer base and offset 0x100004 holds the buffer size. Only bits 31:12 are kept, and bits 11:0 read as 0 and are 0 on the outputs.
- R8: Status reads are sampled in the cycle the access is taken. Offset 0x014 bit 0 is the pending input. Offset 0x104 returns busy on bit 0, read error on bit 1, write error on bit 2, address error on bit 3 and any-error on bit 4. Offset 0x210 returns the acquisition pointer input with bits 6:0 forced to 0.
- R9: Any write to 0x108 pulses dma_clear_pulse. A write to 0x214 with bit 1 set pulses chan_init_pulse. A write to 0x218 with bit 1 set pulses intr_clear_pulse. Each pulse is high for exactly one clock, the cycle in which bus_ready is 1, and the strobe bits read as 0.
- R10: Offset 0x214 bit 0 is the channel enable (chan_enable) and offset 0x218 bit 0 is the acquisition interrupt enable (acq_intr_enable). Both are read/write.
- R11: Reads of unmapped offsets return 0. Writes to read-only or unmapped offsets complete normally and change no register.
- R12: irq is 1 exactly while the interrupt enable bit (0x010 bit 0) is set and irq_pending_in is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion response |
| bus_rdata | output | 32 | Registered read data |
| irq_pending_in | input | 1 | Interrupt pending flag from acquisition logic |
| dma_busy_in | input | 1 | DMA busy flag |
| dma_err_rd_in | input | 1 | DMA read error flag |
| dma_err_wr_in | input | 1 | DMA write error flag |
| dma_err_addr_in | input | 1 | DMA address error flag |
| dma_err_any_in | input | 1 | DMA any-error flag |
| acq_ptr_in | input | 32 | Current acquisition write pointer |
| dma_enable | output | 1 | DMA enable |
| acq_start_addr | output | 32 | Acquisition start address |
| acq_end_addr | output | 32 | Acquisition end address |
| acq_limit_addr | output | 32 | Acquisition limit address |
| acq_intr_addr | output | 32 | Acquisition interrupt address |
| chan_enable | output | 1 | Acquisition channel enable |
| acq_intr_enable | output | 1 | Acquisition interrupt enable |
| led_out | output | 8 | LED test value |
| buf_base | output | 32 | DMA buffer base address |
| buf_size | output | 32 | DMA buffer size |
| dma_clear_pulse | output | 1 | DMA error clear strobe |
| chan_init_pulse | output | 1 | Channel initialise strobe |
| intr_clear_pulse | output | 1 | Acquisition interrupt clear strobe |
| irq | output | 1 | Level interrupt |

## Verification
Address decode is tried with exact offsets and also with addresses carrying junk in the masked-off bits, which shows whether the mask keeps bit 20 and drops bits 16 to 19 and 21 and up. Write data with all-ones low bits separates correct truncation of the address fields at bit 7 and at bit 12 from storing the full word. Status reads are done with a single flag, with a pair of flags and with all five flags set, so that swapped or merged bit positions stand out. Strobe offsets are written both with and without the trigger bit, and the pulse is watched in the response cycle and in the cycle after it, so that a held level or a missing pulse is caught.

// File: rtl/acq_regbank_pkg.sv
package acq_regbank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LED_W  = 8;

    localparam logic [WORD_W-1:0] ADDR_MASK = 32'h0010_FFFC;

    localparam logic [WORD_W-1:0] OFS_INFO      = 32'h0000_0000;
    localparam logic [WORD_W-1:0] OFS_IRQ_EN    = 32'h0000_0010;
    localparam logic [WORD_W-1:0] OFS_IRQ_PEND  = 32'h0000_0014;
    localparam logic [WORD_W-1:0] OFS_DMA_EN    = 32'h0000_0100;
    localparam logic [WORD_W-1:0] OFS_DMA_STS   = 32'h0000_0104;
    localparam logic [WORD_W-1:0] OFS_DMA_CLR   = 32'h0000_0108;
    localparam logic [WORD_W-1:0] OFS_ACQ_START = 32'h0000_0200;
    localparam logic [WORD_W-1:0] OFS_ACQ_END   = 32'h0000_0204;
    localparam logic [WORD_W-1:0] OFS_ACQ_LIMIT = 32'h0000_0208;
    localparam logic [WORD_W-1:0] OFS_ACQ_INTR  = 32'h0000_020C;
    localparam logic [WORD_W-1:0] OFS_ACQ_PTR   = 32'h0000_0210;
    localparam logic [WORD_W-1:0] OFS_CHAN_CTL  = 32'h0000_0214;
    localparam logic [WORD_W-1:0] OFS_INTR_CTL  = 32'h0000_0218;
    localparam logic [WORD_W-1:0] OFS_LED       = 32'h0000_0404;
    localparam logic [WORD_W-1:0] OFS_BUF_BASE  = 32'h0010_0000;
    localparam logic [WORD_W-1:0] OFS_BUF_SIZE  = 32'h0010_0004;

    localparam logic [7:0] ID_TAG    = 8'h4A;
    localparam logic [7:0] API_REV   = 8'd1;
    localparam logic [7:0] REV_MAJOR = 8'd0;
    localparam logic [7:0] REV_MINOR = 8'd3;
    localparam logic [WORD_W-1:0] INFO_WORD = {ID_TAG, API_REV, REV_MAJOR, REV_MINOR};

    // bit positions inside the combined control/strobe words
    localparam int unsigned CTL_LEVEL_BIT  = 0;
    localparam int unsigned CTL_STROBE_BIT = 1;

    // status word bit positions
    localparam int unsigned STS_BUSY     = 0;
    localparam int unsigned STS_ERR_RD   = 1;
    localparam int unsigned STS_ERR_WR   = 2;
    localparam int unsigned STS_ERR_ADDR = 3;
    localparam int unsigned STS_ERR_ANY  = 4;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_INFO,
        SEL_IRQ_EN,
        SEL_IRQ_PEND,
        SEL_DMA_EN,
        SEL_DMA_STS,
        SEL_DMA_CLR,
        SEL_ACQ_START,
        SEL_ACQ_END,
        SEL_ACQ_LIMIT,
        SEL_ACQ_INTR,
        SEL_ACQ_PTR,
        SEL_CHAN_CTL,
        SEL_INTR_CTL,
        SEL_LED,
        SEL_BUF_BASE,
        SEL_BUF_SIZE
    } reg_sel_e;

    typedef struct packed {
        logic              irq_en;
        logic              dma_en;
        logic [WORD_W-1:0] acq_start;
        logic [WORD_W-1:0] acq_end;
        logic [WORD_W-1:0] acq_limit;
        logic [WORD_W-1:0] acq_intr;
        logic              chan_en;
        logic              acq_intr_en;
        logic [LED_W-1:0]  led;
        logic [WORD_W-1:0] buf_base;
        logic [WORD_W-1:0] buf_size;
    } ctrl_t;

    typedef struct packed {
        logic              irq_pend;
        logic              busy;
        logic              err_rd;
        logic              err_wr;
        logic              err_addr;
        logic              err_any;
        logic [WORD_W-1:0] acq_ptr;
    } status_t;

    typedef struct packed {
        logic dma_clr;
        logic chan_init;
        logic intr_clr;
    } strobe_t;

    function automatic logic [WORD_W-1:0] keep_upper(input logic [WORD_W-1:0] v,
                                                     input int unsigned lsb);
        logic [WORD_W-1:0] low_ones;
        low_ones = (WORD_W'(1) << lsb) - WORD_W'(1);
        return v & ~low_ones;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [WORD_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_INFO:      s = SEL_INFO;
            OFS_IRQ_EN:    s = SEL_IRQ_EN;
            OFS_IRQ_PEND:  s = SEL_IRQ_PEND;
            OFS_DMA_EN:    s = SEL_DMA_EN;
            OFS_DMA_STS:   s = SEL_DMA_STS;
            OFS_DMA_CLR:   s = SEL_DMA_CLR;
            OFS_ACQ_START: s = SEL_ACQ_START;
            OFS_ACQ_END:   s = SEL_ACQ_END;
            OFS_ACQ_LIMIT: s = SEL_ACQ_LIMIT;
            OFS_ACQ_INTR:  s = SEL_ACQ_INTR;
            OFS_ACQ_PTR:   s = SEL_ACQ_PTR;
            OFS_CHAN_CTL:  s = SEL_CHAN_CTL;
            OFS_INTR_CTL:  s = SEL_INTR_CTL;
            OFS_LED:       s = SEL_LED;
            OFS_BUF_BASE:  s = SEL_BUF_BASE;
            OFS_BUF_SIZE:  s = SEL_BUF_SIZE;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import acq_regbank_pkg::*;
(
    input  logic [WORD_W-1:0] addr,
    output reg_sel_e          sel
);
    logic [WORD_W-1:0] masked;

    always_comb begin
        masked = addr & ADDR_MASK;
        sel    = decode_offset(masked);
    end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
    import acq_regbank_pkg::*;
#(
    parameter int unsigned ACQ_LSB = 7,
    parameter int unsigned BUF_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IRQ_EN:    q.irq_en      <= wdata[CTL_LEVEL_BIT];
                SEL_DMA_EN:    q.dma_en      <= wdata[CTL_LEVEL_BIT];
                SEL_ACQ_START: q.acq_start   <= keep_upper(wdata, ACQ_LSB);
                SEL_ACQ_END:   q.acq_end     <= keep_upper(wdata, ACQ_LSB);
                SEL_ACQ_LIMIT: q.acq_limit   <= keep_upper(wdata, ACQ_LSB);
                SEL_ACQ_INTR:  q.acq_intr    <= keep_upper(wdata, ACQ_LSB);
                SEL_CHAN_CTL:  q.chan_en     <= wdata[CTL_LEVEL_BIT];
                SEL_INTR_CTL:  q.acq_intr_en <= wdata[CTL_LEVEL_BIT];
                SEL_LED:       q.led         <= wdata[LED_W-1:0];
                SEL_BUF_BASE:  q.buf_base    <= keep_upper(wdata, BUF_LSB);
                SEL_BUF_SIZE:  q.buf_size    <= keep_upper(wdata, BUF_LSB);
                default:       q             <= q;
            endcase
        end
    end
endmodule

// File: rtl/regbank_strobe.sv
module regbank_strobe
    import acq_regbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  logic     strobe_bit,
    output strobe_t  q
);
    strobe_t nxt;

    always_comb begin
        nxt           = '0;
        nxt.dma_clr   = wr_en && (sel == SEL_DMA_CLR);
        nxt.chan_init = wr_en && (sel == SEL_CHAN_CTL) && strobe_bit;
        nxt.intr_clr  = wr_en && (sel == SEL_INTR_CTL) && strobe_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import acq_regbank_pkg::*;
#(
    parameter int unsigned ACQ_LSB = 7
) (
    input  reg_sel_e          sel,
    input  ctrl_t             ctl,
    input  status_t           sts,
    output logic [WORD_W-1:0] value
);
    always_comb begin
        value = '0;
        case (sel)
            SEL_INFO:      value = INFO_WORD;
            SEL_IRQ_EN:    value[CTL_LEVEL_BIT] = ctl.irq_en;
            SEL_IRQ_PEND:  value[0] = sts.irq_pend;
            SEL_DMA_EN:    value[CTL_LEVEL_BIT] = ctl.dma_en;
            SEL_DMA_STS: begin
                value[STS_BUSY]     = sts.busy;
                value[STS_ERR_RD]   = sts.err_rd;
                value[STS_ERR_WR]   = sts.err_wr;
                value[STS_ERR_ADDR] = sts.err_addr;
                value[STS_ERR_ANY]  = sts.err_any;
            end
            SEL_ACQ_START: value = ctl.acq_start;
            SEL_ACQ_END:   value = ctl.acq_end;
            SEL_ACQ_LIMIT: value = ctl.acq_limit;
            SEL_ACQ_INTR:  value = ctl.acq_intr;
            SEL_ACQ_PTR:   value = keep_upper(sts.acq_ptr, ACQ_LSB);
            SEL_CHAN_CTL:  value[CTL_LEVEL_BIT] = ctl.chan_en;
            SEL_INTR_CTL:  value[CTL_LEVEL_BIT] = ctl.acq_intr_en;
            SEL_LED:       value[LED_W-1:0] = ctl.led;
            SEL_BUF_BASE:  value = ctl.buf_base;
            SEL_BUF_SIZE:  value = ctl.buf_size;
            default:       value = '0;
        endcase
    end
endmodule

// File: rtl/acq_regbank.sv
module acq_regbank
    import acq_regbank_pkg::*;
#(
    parameter int unsigned ACQ_LSB = 7,
    parameter int unsigned BUF_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              irq_pending_in,
    input  logic              dma_busy_in,
    input  logic              dma_err_rd_in,
    input  logic              dma_err_wr_in,
    input  logic              dma_err_addr_in,
    input  logic              dma_err_any_in,
    input  logic [WORD_W-1:0] acq_ptr_in,
    output logic              dma_enable,
    output logic [WORD_W-1:0] acq_start_addr,
    output logic [WORD_W-1:0] acq_end_addr,
    output logic [WORD_W-1:0] acq_limit_addr,
    output logic [WORD_W-1:0] acq_intr_addr,
    output logic              chan_enable,
    output logic              acq_intr_enable,
    output logic [LED_W-1:0]  led_out,
    output logic [WORD_W-1:0] buf_base,
    output logic [WORD_W-1:0] buf_size,
    output logic              dma_clear_pulse,
    output logic              chan_init_pulse,
    output logic              intr_clear_pulse,
    output logic              irq
);
    reg_sel_e          sel;
    ctrl_t             ctl;
    status_t           sts;
    strobe_t           stb;
    logic [WORD_W-1:0] rd_value;
    logic              take;
    logic              wr_en;
    logic              rd_en;

    assign take  = bus_valid && !bus_ready;
    assign wr_en = take && bus_write;
    assign rd_en = take && !bus_write;

    always_comb begin
        sts          = '0;
        sts.irq_pend = irq_pending_in;
        sts.busy     = dma_busy_in;
        sts.err_rd   = dma_err_rd_in;
        sts.err_wr   = dma_err_wr_in;
        sts.err_addr = dma_err_addr_in;
        sts.err_any  = dma_err_any_in;
        sts.acq_ptr  = acq_ptr_in;
    end

    regbank_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    regbank_ctrl #(
        .ACQ_LSB (ACQ_LSB),
        .BUF_LSB (BUF_LSB)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (bus_wdata),
        .q     (ctl)
    );

    regbank_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .sel        (sel),
        .strobe_bit (bus_wdata[CTL_STROBE_BIT]),
        .q          (stb)
    );

    regbank_rdmux #(
        .ACQ_LSB (ACQ_LSB)
    ) u_rdmux (
        .sel   (sel),
        .ctl   (ctl),
        .sts   (sts),
        .value (rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= take;
            if (rd_en) bus_rdata <= rd_value;
        end
    end

    assign dma_enable       = ctl.dma_en;
    assign acq_start_addr   = ctl.acq_start;
    assign acq_end_addr     = ctl.acq_end;
    assign acq_limit_addr   = ctl.acq_limit;
    assign acq_intr_addr    = ctl.acq_intr;
    assign chan_enable      = ctl.chan_en;
    assign acq_intr_enable  = ctl.acq_intr_en;
    assign led_out          = ctl.led;
    assign buf_base         = ctl.buf_base;
    assign buf_size         = ctl.buf_size;
    assign dma_clear_pulse  = stb.dma_clr;
    assign chan_init_pulse  = stb.chan_init;
    assign intr_clear_pulse = stb.intr_clr;
    assign irq              = ctl.irq_en && irq_pending_in;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import acq_regbank_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             bus_ready,
    input logic             irq_pending_in,
    input logic [LED_W-1:0] led_out,
    input logic             dma_clear_pulse,
    input logic             chan_init_pulse,
    input logic             intr_clear_pulse,
    input logic             irq
);
    // R2: response lasts a single cycle
    a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    // R2: response only follows a request
    a_r2_ready_after_req: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> $past(bus_valid));

    // R9: strobes are one clock wide
    a_r9_dma_clr_single: assert property (@(posedge clk) disable iff (rst)
        dma_clear_pulse |=> !dma_clear_pulse);

    a_r9_chan_init_single: assert property (@(posedge clk) disable iff (rst)
        chan_init_pulse |=> !chan_init_pulse);

    a_r9_intr_clr_single: assert property (@(posedge clk) disable iff (rst)
        intr_clear_pulse |=> !intr_clear_pulse);

    // R9: strobes coincide with the write response
    a_r9_strobe_in_resp: assert property (@(posedge clk) disable iff (rst)
        (dma_clear_pulse || chan_init_pulse || intr_clear_pulse) |-> (bus_ready && $past(bus_write)));

    // R12: no interrupt without a pending flag
    a_r12_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_pending_in);

    // R5: LED value holds when no write is taken
    a_r5_led_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write && !bus_ready) |=> $stable(led_out));
endmodule

bind acq_regbank regbank_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_valid        (bus_valid),
    .bus_write        (bus_write),
    .bus_ready        (bus_ready),
    .irq_pending_in   (irq_pending_in),
    .led_out          (led_out),
    .dma_clear_pulse  (dma_clear_pulse),
    .chan_init_pulse  (chan_init_pulse),
    .intr_clear_pulse (intr_clear_pulse),
    .irq              (irq)
);

// File: tb/sim_acq_regbank.sv
module sim_acq_regbank;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        irq_pending_in = 1'b0;
    logic        dma_busy_in = 1'b0;
    logic        dma_err_rd_in = 1'b0;
    logic        dma_err_wr_in = 1'b0;
    logic        dma_err_addr_in = 1'b0;
    logic        dma_err_any_in = 1'b0;
    logic [31:0] acq_ptr_in = '0;
    logic        dma_enable;
    logic [31:0] acq_start_addr, acq_end_addr, acq_limit_addr, acq_intr_addr;
    logic        chan_enable, acq_intr_enable;
    logic [7:0]  led_out;
    logic [31:0] buf_base, buf_size;
    logic        dma_clear_pulse, chan_init_pulse, intr_clear_pulse;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic p_dma, p_init, p_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_regbank u0 (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .irq_pending_in(irq_pending_in), .dma_busy_in(dma_busy_in),
        .dma_err_rd_in(dma_err_rd_in), .dma_err_wr_in(dma_err_wr_in),
        .dma_err_addr_in(dma_err_addr_in), .dma_err_any_in(dma_err_any_in),
        .acq_ptr_in(acq_ptr_in), .dma_enable(dma_enable),
        .acq_start_addr(acq_start_addr), .acq_end_addr(acq_end_addr),
        .acq_limit_addr(acq_limit_addr), .acq_intr_addr(acq_intr_addr),
        .chan_enable(chan_enable), .acq_intr_enable(acq_intr_enable),
        .led_out(led_out), .buf_base(buf_base), .buf_size(buf_size),
        .dma_clear_pulse(dma_clear_pulse), .chan_init_pulse(chan_init_pulse),
        .intr_clear_pulse(intr_clear_pulse), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one bus access; returns at the negedge of the response cycle
    task automatic access(input logic wr, input logic [31:0] a,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        for (int n = 0; n < 20 && !bus_ready; n++) @(negedge clk);
        rd     = bus_rdata;
        p_dma  = dma_clear_pulse;
        p_init = chan_init_pulse;
        p_clr  = intr_clear_pulse;
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(1'b1, a, d, dummy);
    endtask

    task automatic rd_check(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] v;
        access(1'b0, a, 32'h0, v);
        check(req, $sformatf("read %h", a), v, exp);
    endtask

    task automatic t_reset;
        check("R1", "bus_ready", {31'd0, bus_ready}, 32'd0);
        check("R1", "dma_enable", {31'd0, dma_enable}, 32'd0);
        check("R1", "acq_start", acq_start_addr, 32'd0);
        check("R1", "buf_size", buf_size, 32'd0);
        check("R1", "led", {24'd0, led_out}, 32'd0);
        check("R1", "strobes", {29'd0, dma_clear_pulse, chan_init_pulse, intr_clear_pulse}, 32'd0);
        check("R1", "irq", {31'd0, irq}, 32'd0);
        rd_check("R1", 32'h010, 32'h0);
        rd_check("R1", 32'h208, 32'h0);
        rd_check("R1", 32'h100004, 32'h0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 32'h0;
        check("R2", "ready before edge", {31'd0, bus_ready}, 32'd0);
        @(negedge clk);
        check("R2", "ready in response cycle", {31'd0, bus_ready}, 32'd1);
        check("R2", "rdata in response cycle", bus_rdata, 32'h4A010003);
        bus_valid = 1'b0;
        @(negedge clk);
        check("R2", "ready after response", {31'd0, bus_ready}, 32'd0);
    endtask

    task automatic t_info;
        rd_check("R4", 32'h000, 32'h4A010003);
        wr(32'h000, 32'hFFFF_FFFF);
        rd_check("R4", 32'h000, 32'h4A010003);
    endtask

    task automatic t_ctrl;
        wr(32'h404, 32'h0000_00A5);
        check("R5", "led after write", {24'd0, led_out}, 32'hA5);
        rd_check("R5", 32'h404, 32'hA5);
        wr(32'h404, 32'hFFFF_FF3C);
        rd_check("R5", 32'h404, 32'h3C);
        wr(32'h100, 32'hFFFF_FFFF);
        check("R5", "dma_enable", {31'd0, dma_enable}, 32'd1);
        rd_check("R5", 32'h100, 32'h1);
        wr(32'h100, 32'h0);
        check("R5", "dma_enable off", {31'd0, dma_enable}, 32'd0);
    endtask

    task automatic t_acq;
        wr(32'h200, 32'h1234_5FFF);
        check("R6", "start out", acq_start_addr, 32'h1234_5F80);
        rd_check("R6", 32'h200, 32'h1234_5F80);
        wr(32'h204, 32'hFFFF_FFFF);
        check("R6", "end out", acq_end_addr, 32'hFFFF_FF80);
        wr(32'h208, 32'h0000_007F);
        check("R6", "limit out", acq_limit_addr, 32'h0);
        wr(32'h20C, 32'h8000_00C0);
        check("R6", "intr out", acq_intr_addr, 32'h8000_0080);
        rd_check("R6", 32'h20C, 32'h8000_0080);
        rd_check("R6", 32'h204, 32'hFFFF_FF80);
    endtask

    task automatic t_buf;
        wr(32'h100000, 32'hABCD_EFFF);
        check("R7", "base out", buf_base, 32'hABCD_E000);
        wr(32'h100004, 32'h0000_3FFF);
        check("R7", "size out", buf_size, 32'h0000_3000);
        rd_check("R7", 32'h100000, 32'hABCD_E000);
        rd_check("R7", 32'h100004, 32'h0000_3000);
    endtask

    task automatic t_alias;
        wr(32'hFFEF_0407, 32'h0000_005A);
        check("R3", "aliased LED write", {24'd0, led_out}, 32'h5A);
        rd_check("R3", 32'h0001_0404, 32'h5A);
        rd_check("R3", 32'h7FF0_0003, 32'hABCD_E000);
        rd_check("R3", 32'h0020_0000, 32'h4A010003);
    endtask

    task automatic t_status;
        dma_busy_in = 1'b1;
        rd_check("R8", 32'h104, 32'h01);
        dma_busy_in = 1'b0; dma_err_addr_in = 1'b1; dma_err_any_in = 1'b1;
        rd_check("R8", 32'h104, 32'h18);
        dma_busy_in = 1'b1; dma_err_rd_in = 1'b1; dma_err_wr_in = 1'b1;
        rd_check("R8", 32'h104, 32'h1F);
        dma_err_rd_in = 1'b0; dma_busy_in = 1'b0;
        rd_check("R8", 32'h104, 32'h1C);
        acq_ptr_in = 32'hDEAD_BEEF;
        rd_check("R8", 32'h210, 32'hDEAD_BE80);
        irq_pending_in = 1'b1;
        rd_check("R8", 32'h014, 32'h1);
        irq_pending_in = 1'b0;
        rd_check("R8", 32'h014, 32'h0);
        wr(32'h104, 32'h0);
        rd_check("R11", 32'h104, 32'h1C);
        dma_err_wr_in = 1'b0; dma_err_addr_in = 1'b0; dma_err_any_in = 1'b0;
    endtask

    task automatic t_strobe;
        wr(32'h108, 32'h0);
        check("R9", "dma clear pulse", {29'd0, p_dma, p_init, p_clr}, 32'h4);
        @(negedge clk);
        check("R9", "dma clear after", {31'd0, dma_clear_pulse}, 32'd0);
        wr(32'h214, 32'h3);
        check("R9", "chan init pulse", {29'd0, p_dma, p_init, p_clr}, 32'h2);
        check("R10", "chan enable", {31'd0, chan_enable}, 32'd1);
        @(negedge clk);
        check("R9", "chan init after", {31'd0, chan_init_pulse}, 32'd0);
        rd_check("R10", 32'h214, 32'h1);
        wr(32'h214, 32'h0);
        check("R9", "no pulse without bit1", {29'd0, p_dma, p_init, p_clr}, 32'h0);
        check("R10", "chan enable off", {31'd0, chan_enable}, 32'd0);
        wr(32'h218, 32'h2);
        check("R9", "intr clear pulse", {29'd0, p_dma, p_init, p_clr}, 32'h1);
        check("R10", "acq intr enable stays", {31'd0, acq_intr_enable}, 32'd0);
        rd_check("R9", 32'h218, 32'h0);
        wr(32'h218, 32'h1);
        check("R10", "acq intr enable", {31'd0, acq_intr_enable}, 32'd1);
        rd_check("R10", 32'h218, 32'h1);
        rd_check("R9", 32'h108, 32'h0);
    endtask

    task automatic t_unmapped;
        rd_check("R11", 32'h400, 32'h0);
        rd_check("R11", 32'h220, 32'h0);
        wr(32'h408, 32'hFFFF_FFFF);
        wr(32'h014, 32'hFFFF_FFFF);
        rd_check("R11", 32'h404, 32'h5A);
        rd_check("R11", 32'h010, 32'h0);
        rd_check("R11", 32'h200, 32'h1234_5F80);
    endtask

    task automatic t_irq;
        wr(32'h010, 32'h1);
        check("R12", "irq enabled no pending", {31'd0, irq}, 32'd0);
        irq_pending_in = 1'b1;
        #1;
        check("R12", "irq enabled pending", {31'd0, irq}, 32'd1);
        rd_check("R12", 32'h010, 32'h1);
        wr(32'h010, 32'h0);
        check("R12", "irq disabled pending", {31'd0, irq}, 32'd0);
        irq_pending_in = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_handshake;
        t_info;
        t_ctrl;
        t_acq;
        t_buf;
        t_alias;
        t_status;
        t_strobe;
        t_unmapped;
        t_irq;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule